// File: doc/BRIEF.md
# Transactional Memory Conflict Detector

Several hardware threads can run the same critical section at the same time as speculative transactions. This block keeps two bit-vector signatures for each thread, one for the speculative reads and one for the speculative writes. Each transactional load or store address is hashed to a single bit index. The block checks that index against the signatures of every other running transaction. If an access clashes with data another transaction has touched, the block asks for the thread that made the access to be aborted. Software then rolls the thread back and retries it. The undo log and the retry policy are not part of this block.

Signatures alias, so two different addresses can share a bit. The block may therefore report a conflict that is not real, but it never misses a real one. A thread is opened with a begin pulse and closed with a commit or abort pulse. Begin, commit and abort each wipe both of that thread's signatures.

Top module: `tm_conflict_detector`

## Requirements
- R1: After reset all abort requests are low, every signature is empty and every thread is outside a transaction.
- R2: The signature index is the XOR of consecutive SIG_W-log2 bit chunks of the word address (address bits above bit 1). The highest chunk is zero-padded.
- R3: Two reads that map to the same index in different transactions do not cause an abort.
- R4: A write whose index is set in another running transaction's read or write signature aborts the writer.
- R5: A read whose index is set in another running transaction's write signature aborts the reader.
- R6: Different addresses that hash to the same index are treated as the same address, so aliasing can produce a false conflict.
- R7: An abort request is raised in the cycle after the offending access and lasts one cycle per conflicting access. The thread that already holds the data is never aborted.
- R8: Two eligible accesses in the same cycle on the same index conflict when at least one of them is a write. In that case only the thread with the higher index is aborted.
- R9: An access with the transaction flag low, or from a thread that is not inside a transaction, is not recorded and causes no abort.
- R10: After a commit or abort pulse, the thread's accesses no longer conflict with anything.
- R11: An access that is aborted is not recorded in the requester's signature.
- R12: If a begin, commit or abort pulse arrives in the same cycle as an access from the same thread, the access is ignored. When commit or abort coincides with begin, commit or abort wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| begin_i | input | N_THR | Per-thread transaction start pulse |
| commit_i | input | N_THR | Per-thread commit pulse |
| abort_i | input | N_THR | Per-thread software abort pulse |
| acc_vld_i | input | N_THR | Per-thread access strobe |
| acc_tx_i | input | N_THR | Access is transactional |
| acc_wr_i | input | N_THR | 1 = store, 0 = load |
| acc_addr_i | input | N_THR*ADDR_W | Byte addresses, thread t at bits [t*ADDR_W +: ADDR_W] |
| abort_req_o | output | N_THR | One-cycle abort request per conflicting access |

## Verification
The bench builds the block with four threads, 16-bit addresses and 16-bit signatures. With only 16 signature bits, aliasing between random addresses is frequent. This makes false conflicts and same-cycle races between all four threads common under random traffic, so they are checked against a bench model of the signature rules. Directed cases cover the read/read, read/write, write/write and alias cases, same-cycle ties, non-transactional traffic, and control pulses that coincide with accesses.

// File: rtl/tmcd_pkg.sv
package tmcd_pkg;
  typedef enum logic {TX_IDLE = 1'b0, TX_RUN = 1'b1} tx_state_e;
endpackage

// File: rtl/tmcd_hash.sv
module tmcd_hash #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SIG_W  = 256
) (
  input  logic [ADDR_W-1:0]         addr_i,
  output logic [$clog2(SIG_W)-1:0]  idx_o
);
  localparam int unsigned IDX_W   = $clog2(SIG_W);
  localparam int unsigned WA_W    = ADDR_W - 2;
  localparam int unsigned N_CHUNK = (WA_W + IDX_W - 1) / IDX_W;
  localparam int unsigned PAD_W   = N_CHUNK * IDX_W;

  logic [PAD_W-1:0] word_pad;
  logic [IDX_W-1:0] part [N_CHUNK+1];

  assign word_pad = PAD_W'(addr_i[ADDR_W-1:2]);
  assign part[0]  = '0;

  for (genvar g = 0; g < N_CHUNK; g++) begin : g_fold
    assign part[g+1] = part[g] ^ word_pad[g*IDX_W +: IDX_W];
  end

  assign idx_o = part[N_CHUNK];
endmodule

// File: rtl/tmcd_sig_bank.sv
module tmcd_sig_bank #(
  parameter int unsigned SIG_W = 256
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      set_rd_i,
  input  logic                      set_wr_i,
  input  logic [$clog2(SIG_W)-1:0]  idx_i,
  output logic [SIG_W-1:0]          rd_sig_o,
  output logic [SIG_W-1:0]          wr_sig_o
);
  logic [SIG_W-1:0] rd_q, wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
      wr_q <= '0;
    end else if (clr_i) begin
      rd_q <= '0;
      wr_q <= '0;
    end else begin
      if (set_rd_i) rd_q[idx_i] <= 1'b1;
      if (set_wr_i) wr_q[idx_i] <= 1'b1;
    end
  end

  assign rd_sig_o = rd_q;
  assign wr_sig_o = wr_q;

  assert_clear_empties_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (rd_sig_o == '0) && (wr_sig_o == '0));

  assert_record_sticks_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_wr_i && !clr_i) |=> wr_sig_o[$past(idx_i)]);
endmodule

// File: rtl/tmcd_conflict_chk.sv
module tmcd_conflict_chk #(
  parameter int unsigned N_THR  = 4,
  parameter int unsigned SIG_W  = 256,
  parameter int unsigned THR_ID = 0
) (
  input  logic                      my_vld_i,
  input  logic                      my_wr_i,
  input  logic [$clog2(SIG_W)-1:0]  my_idx_i,
  input  logic [N_THR-1:0]          act_i,
  input  logic [SIG_W-1:0]          rsig_i [N_THR],
  input  logic [SIG_W-1:0]          wsig_i [N_THR],
  input  logic [N_THR-1:0]          cvld_i,
  input  logic [N_THR-1:0]          cwr_i,
  input  logic [$clog2(SIG_W)-1:0]  cidx_i [N_THR],
  output logic                      hit_o
);
  logic [N_THR-1:0] sig_hit, race_hit;

  always_comb begin
    for (int j = 0; j < N_THR; j++) begin
      sig_hit[j]  = 1'b0;
      race_hit[j] = 1'b0;
      if (j != int'(THR_ID)) begin
        sig_hit[j] = act_i[j] &&
                     (wsig_i[j][my_idx_i] || (my_wr_i && rsig_i[j][my_idx_i]));
      end
      // same-cycle tie: lower index wins
      if (j < int'(THR_ID)) begin
        race_hit[j] = cvld_i[j] && (cidx_i[j] == my_idx_i) && (my_wr_i || cwr_i[j]);
      end
    end
    hit_o = my_vld_i && (|(sig_hit | race_hit));
  end
endmodule

// File: rtl/tm_conflict_detector.sv
module tm_conflict_detector
  import tmcd_pkg::*;
#(
  parameter int unsigned N_THR  = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SIG_W  = 256
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_THR-1:0]        begin_i,
  input  logic [N_THR-1:0]        commit_i,
  input  logic [N_THR-1:0]        abort_i,
  input  logic [N_THR-1:0]        acc_vld_i,
  input  logic [N_THR-1:0]        acc_tx_i,
  input  logic [N_THR-1:0]        acc_wr_i,
  input  logic [N_THR*ADDR_W-1:0] acc_addr_i,
  output logic [N_THR-1:0]        abort_req_o
);
  localparam int unsigned IDX_W = $clog2(SIG_W);

  tx_state_e        st_q [N_THR];
  logic [N_THR-1:0] act, ctl_any, elig, hit, rec;
  logic [IDX_W-1:0] idx  [N_THR];
  logic [SIG_W-1:0] rsig [N_THR];
  logic [SIG_W-1:0] wsig [N_THR];
  logic [N_THR-1:0] abort_q;

  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    assign act[t]     = (st_q[t] == TX_RUN);
    assign ctl_any[t] = begin_i[t] | commit_i[t] | abort_i[t];
    assign elig[t]    = acc_vld_i[t] & acc_tx_i[t] & act[t] & ~ctl_any[t];
    assign rec[t]     = elig[t] & ~hit[t];

    tmcd_hash #(.ADDR_W(ADDR_W), .SIG_W(SIG_W)) u_hash (
      .addr_i (acc_addr_i[t*ADDR_W +: ADDR_W]),
      .idx_o  (idx[t])
    );

    tmcd_sig_bank #(.SIG_W(SIG_W)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (ctl_any[t]),
      .set_rd_i (rec[t] & ~acc_wr_i[t]),
      .set_wr_i (rec[t] &  acc_wr_i[t]),
      .idx_i    (idx[t]),
      .rd_sig_o (rsig[t]),
      .wr_sig_o (wsig[t])
    );

    tmcd_conflict_chk #(.N_THR(N_THR), .SIG_W(SIG_W), .THR_ID(t)) u_chk (
      .my_vld_i (elig[t]),
      .my_wr_i  (acc_wr_i[t]),
      .my_idx_i (idx[t]),
      .act_i    (act),
      .rsig_i   (rsig),
      .wsig_i   (wsig),
      .cvld_i   (elig),
      .cwr_i    (acc_wr_i),
      .cidx_i   (idx),
      .hit_o    (hit[t])
    );

    // commit/abort dominate begin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      st_q[t] <= TX_IDLE;
      else if (commit_i[t] | abort_i[t]) st_q[t] <= TX_IDLE;
      else if (begin_i[t])              st_q[t] <= TX_RUN;
    end

    assert_abort_needs_tx_access_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abort_req_o[t] |-> $past(acc_vld_i[t] && acc_tx_i[t]));

    assert_ctl_masks_access_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(begin_i[t] || commit_i[t] || abort_i[t]) |-> !abort_req_o[t]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) abort_q <= '0;
    else         abort_q <= hit;
  end

  assign abort_req_o = abort_q;

  assert_thread0_race_safe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elig[0] && !act[1] && !act[2] && !act[3]) |=> !abort_req_o[0]);
endmodule

// File: tb/sim_tm_conflict_detector.sv
module sim_tm_conflict_detector;
  localparam int NT = 4;
  localparam int AW = 16;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NT-1:0] b_beg, b_com, b_abt, b_vld, b_tx, b_wr;
  logic [AW-1:0] b_addr [NT];
  logic [NT*AW-1:0] addr_flat;
  logic [NT-1:0] abort_req;

  int checks = 0;
  int fails  = 0;

  logic [SW-1:0] m_rs [NT];
  logic [SW-1:0] m_ws [NT];
  logic [NT-1:0] m_act;
  logic [NT-1:0] exp_abort;

  always #4ns clk = ~clk;

  always_comb
    for (int t = 0; t < NT; t++) addr_flat[t*AW +: AW] = b_addr[t];

  tm_conflict_detector #(.N_THR(NT), .ADDR_W(AW), .SIG_W(SW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .begin_i(b_beg), .commit_i(b_com), .abort_i(b_abt),
    .acc_vld_i(b_vld), .acc_tx_i(b_tx), .acc_wr_i(b_wr), .acc_addr_i(addr_flat),
    .abort_req_o(abort_req)
  );

  function automatic logic [3:0] bhash(input logic [AW-1:0] a);
    logic [13:0] w;
    w = a[15:2];
    return w[3:0] ^ w[7:4] ^ w[11:8] ^ {2'b00, w[13:12]};
  endfunction

  task automatic clr_in();
    b_beg = '0; b_com = '0; b_abt = '0; b_vld = '0; b_tx = '0; b_wr = '0;
    for (int t = 0; t < NT; t++) b_addr[t] = '0;
  endtask

  task automatic acc(input int t, input logic wr, input logic [AW-1:0] a);
    b_vld[t] = 1'b1; b_tx[t] = 1'b1; b_wr[t] = wr; b_addr[t] = a;
  endtask

  task automatic model_step();
    logic [NT-1:0] el, hit;
    logic [3:0] ix [NT];
    for (int i = 0; i < NT; i++) begin
      ix[i] = bhash(b_addr[i]);
      el[i] = b_vld[i] && b_tx[i] && m_act[i] && !(b_beg[i] || b_com[i] || b_abt[i]);
    end
    for (int i = 0; i < NT; i++) begin
      hit[i] = 1'b0;
      if (el[i]) begin
        for (int j = 0; j < NT; j++) begin
          if (j != i && m_act[j] && (m_ws[j][ix[i]] || (b_wr[i] && m_rs[j][ix[i]])))
            hit[i] = 1'b1;
          if (j < i && el[j] && ix[j] == ix[i] && (b_wr[i] || b_wr[j]))
            hit[i] = 1'b1;
        end
      end
    end
    for (int i = 0; i < NT; i++) begin
      if (b_beg[i] || b_com[i] || b_abt[i]) begin
        m_rs[i] = '0; m_ws[i] = '0;
        m_act[i] = (b_com[i] || b_abt[i]) ? 1'b0 : 1'b1;
      end else if (el[i] && !hit[i]) begin
        if (b_wr[i]) m_ws[i][ix[i]] = 1'b1;
        else         m_rs[i][ix[i]] = 1'b1;
      end
    end
    exp_abort = hit;
  endtask

  task automatic tick(input string req);
    model_step();
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (abort_req !== exp_abort) begin
      fails++;
      $display("FAIL %s abort_req actual=%b expected=%b", req, abort_req, exp_abort);
    end
    clr_in();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    clr_in();
    m_act = '0; exp_abort = '0;
    for (int t = 0; t < NT; t++) begin m_rs[t] = '0; m_ws[t] = '0; end
    repeat (3) @(negedge clk);
    checks++;
    if (abort_req !== '0) begin
      fails++;
      $display("FAIL R1 abort_req in reset actual=%b expected=0000", abort_req);
    end
    rst_n = 1'b1;
    @(negedge clk);
    tick("R1");

    // begin with coincident access from t0: access dropped
    b_beg = 4'b0111; acc(0, 1'b1, 16'h0004);
    tick("R12");
    acc(0, 1'b0, 16'h0004); acc(1, 1'b0, 16'h0004);
    tick("R3");
    acc(1, 1'b1, 16'h0004);
    tick("R4");
    tick("R7");
    acc(0, 1'b1, 16'h0008); acc(2, 1'b0, 16'h0008);
    tick("R8");
    acc(1, 1'b0, 16'h0008);
    tick("R5");
    acc(2, 1'b1, 16'h4000); // aliases 0x0004
    tick("R6");
    acc(0, 1'b1, 16'h000C); acc(1, 1'b1, 16'h000C);
    tick("R8");
    acc(3, 1'b1, 16'h0004); b_vld[2] = 1'b1; b_wr[2] = 1'b1; b_addr[2] = 16'h0008;
    tick("R9");
    b_com[0] = 1'b1;
    tick("R12");
    acc(2, 1'b0, 16'h0004);
    tick("R11");
    acc(2, 1'b1, 16'h0008);
    tick("R10");
    b_abt = 4'b0111; b_beg[0] = 1'b1; acc(1, 1'b1, 16'h0010);
    tick("R12");
    acc(0, 1'b1, 16'h0010); acc(1, 1'b1, 16'h0010);
    tick("R9");

    for (int n = 0; n < 3000; n++) begin
      for (int t = 0; t < NT; t++) begin
        int r;
        r = int'($urandom % 100);
        if (r < 4)      b_beg[t] = 1'b1;
        else if (r < 7) b_com[t] = 1'b1;
        else if (r < 9) b_abt[t] = 1'b1;
        if (($urandom % 100) < 60) begin
          b_vld[t] = 1'b1;
          b_tx[t]  = (($urandom % 8) != 0);
          b_wr[t]  = $urandom % 2;
          b_addr[t] = ($urandom % 2) ? 16'($urandom) : {10'd0, 4'($urandom % 8), 2'b00};
        end
      end
      tick("random R2 R4 R5 R6 R8");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule